// File: doc/BRIEF.md
# Two-Level Predecoded Row Decoder

This block turns a row address into a one-hot set of wordline enables for a memory array. Rather than comparing the full address against every row, it cuts the address into small fields. Each field drives its own predecoder, and each predecoder gives a 1-of-N code. Every wordline is the AND of one line from each predecoder and a qualifying enable.

The address and the enable are both captured on the rising clock edge, so the predecoded lines are steady before the final stage acts on them. A wordline can rise only in a cycle whose captured enable is high. Outside that window every wordline stays low.

The default build uses two 2-bit fields to make 16 wordlines. The field width and the number of fields are parameters. Field 0 is the lowest-order address bits and picks a line within a run of neighbouring wordlines. The higher fields pick the run.

Top module: `wordline_decoder`

## Requirements
- R1: While `rst` is high at a rising edge, the next cycle shows `wordline` as all zeros.
- R2: `row_addr` and `wl_en` are sampled only at the rising edge of `clk`. `wordline` shows the values captured one edge earlier, and a change between edges has no effect until the next edge.
- R3: With the captured enable high, exactly bit `row_addr` of `wordline` is high, so the wordline index equals the captured address as an unsigned number.
- R4: With the captured enable low, `wordline` is all zeros whatever the captured address is.
- R5: At no time is more than one bit of `wordline` high. Each predecoder's output holds exactly one high line.
- R6: Address bits [1:0] select the position within a run of four wordlines, and bits [3:2] select the run. For example, address 3 gives wordline 3, address 4 gives wordline 4, and address 15 gives wordline 15.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the address and enable are captured on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| row_addr | input | GRP_W*N_GRP (4) | Row address |
| wl_en | input | 1 | Wordline enable for the next cycle |
| wordline | output | 2**(GRP_W*N_GRP) (16) | One-hot wordline enables |

## Verification
The checker checks on every cycle that at most one wordline is high and that each predecoder holds a single active line. It also checks that a cycle whose captured enable was low shows no wordline, that an enabled cycle raises the line named by the previous cycle's address, and that reset clears the output.

Some behaviours only the bench's scenarios can show. These are a full sweep of all sixteen addresses, the run boundaries between fields, and a disabled sweep across every address. The bench also shows that an address change made just after an edge stays invisible until the following edge.

// File: rtl/wl_dec_pkg.sv
package wl_dec_pkg;

    // Default geometry: two fields of two bits each
    localparam int DEF_GRP_W = 2;
    localparam int DEF_N_GRP = 2;

    // Extract field g (width w) from a wordline index
    function automatic int field_of(input int idx, input int g, input int w);
        return (idx >> (g * w)) & ((1 << w) - 1);
    endfunction

endpackage

// File: rtl/wl_predecoder.sv
module wl_predecoder #(
    parameter int GRP_W = 2,
    localparam int LINES = 1 << GRP_W
) (
    input  logic [GRP_W-1:0] field_in,
    output logic [LINES-1:0] lines
);

    for (genvar j = 0; j < LINES; j++) begin : g_line
        assign lines[j] = (field_in == GRP_W'(j));
    end

endmodule

// File: rtl/wl_and_plane.sv
module wl_and_plane
    import wl_dec_pkg::*;
#(
    parameter int GRP_W = 2,
    parameter int N_GRP = 2,
    localparam int LINES = 1 << GRP_W,
    localparam int N_WL  = 1 << (GRP_W * N_GRP)
) (
    input  logic [N_GRP*LINES-1:0] pre,
    input  logic                   en,
    output logic [N_WL-1:0]        wl
);

    always_comb begin
        for (int i = 0; i < N_WL; i++) begin
            logic hit;
            hit = en;
            for (int g = 0; g < N_GRP; g++) begin
                hit = hit & pre[g*LINES + field_of(i, g, GRP_W)];
            end
            wl[i] = hit;
        end
    end

endmodule

// File: rtl/wordline_decoder.sv
module wordline_decoder
    import wl_dec_pkg::*;
#(
    parameter int GRP_W = DEF_GRP_W,
    parameter int N_GRP = DEF_N_GRP,
    localparam int ADDR_W = GRP_W * N_GRP,
    localparam int LINES  = 1 << GRP_W,
    localparam int N_WL   = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] row_addr,
    input  logic              wl_en,
    output logic [N_WL-1:0]   wordline
);

    typedef struct packed {
        logic              en;
        logic [ADDR_W-1:0] addr;
    } stage_t;

    stage_t                 stage_q;
    logic [N_GRP*LINES-1:0] pre_lines;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_q <= '0;
        end else begin
            stage_q.en   <= wl_en;
            stage_q.addr <= row_addr;
        end
    end

    for (genvar g = 0; g < N_GRP; g++) begin : g_pre
        wl_predecoder #(.GRP_W(GRP_W)) u_pre (
            .field_in (stage_q.addr[g*GRP_W +: GRP_W]),
            .lines    (pre_lines[g*LINES +: LINES])
        );
    end

    wl_and_plane #(.GRP_W(GRP_W), .N_GRP(N_GRP)) u_plane (
        .pre (pre_lines),
        .en  (stage_q.en),
        .wl  (wordline)
    );

endmodule

// File: rtl/wl_dec_chk.sv
module wl_dec_chk #(
    parameter int GRP_W = 2,
    parameter int N_GRP = 2,
    localparam int ADDR_W = GRP_W * N_GRP,
    localparam int LINES  = 1 << GRP_W,
    localparam int N_WL   = 1 << ADDR_W
) (
    input logic                   clk,
    input logic                   rst,
    input logic [ADDR_W-1:0]      row_addr,
    input logic                   wl_en,
    input logic [N_WL-1:0]        wordline,
    input logic [N_GRP*LINES-1:0] pre_lines
);

    logic seen_edge;
    always_ff @(posedge clk) seen_edge <= 1'b1;

    // R1
    reset_clears_chk: assert property (@(posedge clk)
        (seen_edge && $past(rst)) |-> (wordline == '0));

    // R5
    one_wordline_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(wordline));

    for (genvar g = 0; g < N_GRP; g++) begin : g_pchk
        // R5
        predecode_onehot_chk: assert property (@(posedge clk) disable iff (rst)
            $countones(pre_lines[g*LINES +: LINES]) == 1);
    end

    // R4
    disabled_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (seen_edge && !$past(wl_en)) |-> (wordline == '0));

    // R3
    enabled_select_chk: assert property (@(posedge clk) disable iff (rst)
        (seen_edge && $past(wl_en) && !$past(rst))
            |-> (wordline == (N_WL'(1) << $past(row_addr))));

endmodule

bind wordline_decoder wl_dec_chk #(.GRP_W(GRP_W), .N_GRP(N_GRP)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .row_addr  (row_addr),
    .wl_en     (wl_en),
    .wordline  (wordline),
    .pre_lines (pre_lines)
);

// File: tb/sim_wordline_decoder.sv
`timescale 1ns/1ps
module sim_wordline_decoder;

    localparam int ADDR_W = 4;
    localparam int N_WL   = 16;

    typedef struct {
        logic [N_WL-1:0] exp;
        string           tag;
    } item_t;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [ADDR_W-1:0] row_addr = '0;
    logic              wl_en = 1'b0;
    logic [N_WL-1:0]   wordline;

    int tests = 0;
    int fails = 0;
    item_t sb_q[$];
    bit done = 1'b0;

    always #10 clk = ~clk;

    wordline_decoder u0 (
        .clk      (clk),
        .rst      (rst),
        .row_addr (row_addr),
        .wl_en    (wl_en),
        .wordline (wordline)
    );

    function automatic logic [N_WL-1:0] model(input logic r, input logic e,
                                              input logic [ADDR_W-1:0] a);
        if (r || !e) return '0;
        return N_WL'(1) << a;
    endfunction

    task automatic apply(input logic r, input logic e,
                         input logic [ADDR_W-1:0] a, input string tag);
        item_t it;
        @(negedge clk);
        rst = r; wl_en = e; row_addr = a;
        it.exp = model(r, e, a);
        it.tag = tag;
        sb_q.push_back(it);
    endtask

    // Monitor: compare 5 ns after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #5;
            if (sb_q.size() > 0) begin
                item_t it;
                it = sb_q.pop_front();
                tests++;
                if (wordline !== it.exp) begin
                    fails++;
                    $display("FAIL %s: wordline=%h expected=%h", it.tag, wordline, it.exp);
                end
                tests++;
                if ($countones(wordline) > 1) begin
                    fails++;
                    $display("FAIL R5: wordline=%h expected at most one bit", wordline);
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        // R1: reset forces zero even with enable and address set
        apply(1'b1, 1'b1, 4'd5, "R1");
        apply(1'b1, 1'b1, 4'd9, "R1");
        // R3: full enabled sweep
        for (int a = 0; a < N_WL; a++) apply(1'b0, 1'b1, ADDR_W'(a), "R3");
        // R4: disabled sweep over every address
        for (int a = N_WL - 1; a >= 0; a--) apply(1'b0, 1'b0, ADDR_W'(a), "R4");
        // R6: run boundaries and ends
        apply(1'b0, 1'b1, 4'd3,  "R6");
        apply(1'b0, 1'b1, 4'd4,  "R6");
        apply(1'b0, 1'b1, 4'd11, "R6");
        apply(1'b0, 1'b1, 4'd12, "R6");
        apply(1'b0, 1'b1, 4'd0,  "R6");
        apply(1'b0, 1'b1, 4'd15, "R6");
        // R5: toggling enable and hopping addresses
        apply(1'b0, 1'b1, 4'd7,  "R5");
        apply(1'b0, 1'b0, 4'd8,  "R5");
        apply(1'b0, 1'b1, 4'd8,  "R5");
        apply(1'b0, 1'b1, 4'd1,  "R5");
        // R2: change the address just after the edge; the old capture must still show
        apply(1'b0, 1'b1, 4'd2, "R2");
        @(posedge clk);
        #2 row_addr = 4'd13; wl_en = 1'b0;
        apply(1'b0, 1'b1, 4'd6, "R2");
        // R1: reset in the middle of enabled operation
        apply(1'b1, 1'b1, 4'd6, "R1");
        apply(1'b0, 1'b1, 4'd10, "R3");
        @(negedge clk);
        wl_en = 1'b0;
        wait (sb_q.size() == 0);
        repeat (2) @(posedge clk);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule